// File: doc/BRIEF.md
# Two-Floor Elevator Controller

This block is the sequencing core of a lift that serves two landings. A registered state machine holds six states. Each state is a 3-bit code whose bits drive the door, motion and direction controls directly. The same code is therefore both the machine's state and its output word, and no separate output decode follows it.

Two call flags remember pending service, one for each floor. A flag is raised by a landing (hall) button, by the in-car floor button, or by the in-car door-open button. Which in-car buttons count for a floor depends on the current direction bit. A flag drops by itself once the car rests at its floor with the door open.

A floor sensor pulse ends each trip. The controller clock is deliberately slow: one clock period is the time the door spends open at a floor.

Top module: `elev_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted on a clock edge, the controller enters the resting-at-floor-1 state (code 000) and both call flags are cleared.
- R2: The outputs {door_closed, moving, dir_down} equal the state code. The codes are: rest-floor-1 000, closed-floor-1 100, going-up 110, rest-floor-2 001, closed-floor-2 101, going-down 111. door_closed=1 means the door is shut, moving=1 means travelling, and dir_down=1 means downward.
- R3: From rest-floor-1 the next state is going-up when call2 is set, else closed-floor-1. From rest-floor-2 the next state is going-down when call1 is set, else closed-floor-2.
- R4: Going-up moves to rest-floor-2 on a clock edge where arrive_i is high. Going-down moves to rest-floor-1 on such an edge. With arrive_i low, both states hold.
- R5: From closed-floor-1 the next state is going-up when call2 is set. Otherwise it is rest-floor-1 when call1 is set. With neither flag set, the state holds.
- R6: From closed-floor-2 the next state is going-down when call1 is set. Otherwise it is rest-floor-2 when call2 is set. With neither flag set, the state holds.
- R7: call1 becomes 1 on the edge after hall_req1 is high, or car_open is high while dir_down=0, or car_go1 is high while dir_down=1. It keeps that value until it is cleared.
- R8: call2 becomes 1 on the edge after hall_req2 is high, or car_open is high while dir_down=1, or car_go2 is high while dir_down=0. It keeps that value until it is cleared.
- R9: call1 is cleared on every edge where the state is rest-floor-1, and call2 on every edge where the state is rest-floor-2. A set request arriving on the same edge has no effect; clear wins.
- R10: call1_n and call2_n are always the complements of call1 and call2.
- R11: The codes 010 and 011 never appear on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow controller clock; one period is the door dwell time |
| rst | input | 1 | Synchronous reset, active high |
| hall_req1 | input | 1 | Landing call button at floor 1 |
| hall_req2 | input | 1 | Landing call button at floor 2 |
| car_go1 | input | 1 | In-car button for floor 1 |
| car_go2 | input | 1 | In-car button for floor 2 |
| car_open | input | 1 | In-car door-open button |
| arrive_i | input | 1 | Floor sensor: car has reached the target landing |
| door_closed | output | 1 | 1 = door shut, 0 = door open |
| moving | output | 1 | 1 = car travelling, 0 = waiting |
| dir_down | output | 1 | 1 = downward direction, 0 = upward |
| call1 | output | 1 | Pending service flag for floor 1 |
| call1_n | output | 1 | Complement of call1 |
| call2 | output | 1 | Pending service flag for floor 2 |
| call2_n | output | 1 | Complement of call2 |

## Verification
The block has a single fixed configuration. The bench builds it with the latch reset value at its default of 0, so every state and both flags are reachable from reset. Directed sequences cover the idle door-closing, the reopen at floor 1 and a request pressed while resting at the same floor. A long stretch of sparse random button and sensor activity then drives every transition, including direction-dependent flag setting and set-versus-clear collisions. A behavioural model compares against all outputs on every cycle.

// File: rtl/elev_pkg.sv
package elev_pkg;
  // Bit 2: door shut, bit 1: moving, bit 0: downward
  localparam int STATE_W = 3;
  localparam int DOOR_BIT = 2;
  localparam int MOVE_BIT = 1;
  localparam int DIR_BIT  = 0;
  localparam int N_FLOORS = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_REST1  = 3'b000,
    ST_CLOSE1 = 3'b100,
    ST_GOUP   = 3'b110,
    ST_REST2  = 3'b001,
    ST_CLOSE2 = 3'b101,
    ST_GODN   = 3'b111
  } elev_state_e;
endpackage

// File: rtl/elev_call_latch.sv
module elev_call_latch #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RESET_VAL;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q_o);
  p_set_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> q_o);
endmodule

// File: rtl/elev_fsm.sv
module elev_fsm
  import elev_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        flag1_i,
  input  logic        flag2_i,
  input  logic        arrive_i,
  output elev_state_e state_q
);
  elev_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_REST1:  state_d = flag2_i ? ST_GOUP : ST_CLOSE1;
      ST_REST2:  state_d = flag1_i ? ST_GODN : ST_CLOSE2;
      ST_GOUP:   if (arrive_i) state_d = ST_REST2;
      ST_GODN:   if (arrive_i) state_d = ST_REST1;
      ST_CLOSE1: begin
        if (flag2_i)      state_d = ST_GOUP;
        else if (flag1_i) state_d = ST_REST1;
      end
      ST_CLOSE2: begin
        if (flag1_i)      state_d = ST_GODN;
        else if (flag2_i) state_d = ST_REST2;
      end
      default:   state_d = ST_REST1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_REST1;
    else     state_q <= state_d;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> state_q == ST_REST1);
  p_up_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GOUP && !arrive_i) |=> state_q == ST_GOUP);
  p_up_arrive_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GOUP && arrive_i) |=> state_q == ST_REST2);
  p_rest1_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REST1) |=> (state_q == ST_GOUP || state_q == ST_CLOSE1));
  p_close1_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CLOSE1 && !flag1_i && !flag2_i) |=> state_q == ST_CLOSE1);
  p_close2_call1_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CLOSE2 && flag1_i) |=> state_q == ST_GODN);
  p_legal_r11: assert property (@(posedge clk) disable iff (rst)
    state_q[DOOR_BIT] || !state_q[MOVE_BIT]);
endmodule

// File: rtl/elev_ctrl.sv
module elev_ctrl
  import elev_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hall_req1,
  input  logic hall_req2,
  input  logic car_go1,
  input  logic car_go2,
  input  logic car_open,
  input  logic arrive_i,
  output logic door_closed,
  output logic moving,
  output logic dir_down,
  output logic call1,
  output logic call1_n,
  output logic call2,
  output logic call2_n
);
  elev_state_e        state;
  logic [N_FLOORS-1:0] set_v, clr_v, flag_v;
  logic               dn;

  assign dn = state[DIR_BIT];

  // Index 0 serves floor 1, index 1 serves floor 2
  assign set_v[0] = hall_req1 | (car_open & ~dn) | (car_go1 &  dn);
  assign set_v[1] = hall_req2 | (car_open &  dn) | (car_go2 & ~dn);
  assign clr_v[0] = (state == ST_REST1);
  assign clr_v[1] = (state == ST_REST2);

  for (genvar g = 0; g < N_FLOORS; g++) begin : g_call
    elev_call_latch #(.RESET_VAL(1'b0)) u_latch (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_v[g]),
      .clr_i(clr_v[g]),
      .q_o  (flag_v[g])
    );
  end

  elev_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .flag1_i (flag_v[0]),
    .flag2_i (flag_v[1]),
    .arrive_i(arrive_i),
    .state_q (state)
  );

  assign door_closed = state[DOOR_BIT];
  assign moving      = state[MOVE_BIT];
  assign dir_down    = state[DIR_BIT];
  assign call1       = flag_v[0];
  assign call2       = flag_v[1];
  assign call1_n     = ~flag_v[0];
  assign call2_n     = ~flag_v[1];

  p_comp_r10: assert property (@(posedge clk) disable iff (rst)
    (call1 != call1_n) && (call2 != call2_n));
  p_rest_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (door_closed == 1'b0 && dir_down == 1'b0) |=> !call1);
  p_hall2_r8: assert property (@(posedge clk) disable iff (rst)
    (hall_req2 && !(door_closed == 1'b0 && dir_down == 1'b1)) |=> call2);
endmodule

// File: tb/elev_ctrl_tb_top.sv
module elev_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hall_req1 = 0, hall_req2 = 0, car_go1 = 0, car_go2 = 0;
  logic car_open = 0, arrive_i = 0;
  logic door_closed, moving, dir_down, call1, call1_n, call2, call2_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elev_ctrl dut_i (
    .clk(clk), .rst(rst),
    .hall_req1(hall_req1), .hall_req2(hall_req2),
    .car_go1(car_go1), .car_go2(car_go2), .car_open(car_open),
    .arrive_i(arrive_i),
    .door_closed(door_closed), .moving(moving), .dir_down(dir_down),
    .call1(call1), .call1_n(call1_n), .call2(call2), .call2_n(call2_n)
  );

  // Reference model: states as integers, codes from the requirement table
  int m_st = 0;        // 0 rest1,1 close1,2 up,3 rest2,4 close2,5 down
  int m_prev = 0;
  bit m_f1 = 0, m_f2 = 0;
  bit m_clr1 = 0, m_clr2 = 0;

  function automatic logic [2:0] code_of(int s);
    case (s)
      0: return 3'b000;
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b001;
      4: return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  always @(posedge clk) begin
    int ns;
    bit d, n1, n2;
    m_prev = m_st;
    if (rst) begin
      m_st = 0; m_f1 = 0; m_f2 = 0; m_clr1 = 0; m_clr2 = 0;
    end else begin
      d = (m_st == 3 || m_st == 4 || m_st == 5);
      ns = m_st;
      case (m_st)
        0: ns = m_f2 ? 2 : 1;
        3: ns = m_f1 ? 5 : 4;
        2: if (arrive_i) ns = 3;
        5: if (arrive_i) ns = 0;
        1: if (m_f2) ns = 2; else if (m_f1) ns = 0;
        default: if (m_f1) ns = 5; else if (m_f2) ns = 3;
      endcase
      m_clr1 = (m_st == 0);
      m_clr2 = (m_st == 3);
      n1 = m_clr1 ? 1'b0 : (m_f1 | hall_req1 | (car_open & !d) | (car_go1 & d));
      n2 = m_clr2 ? 1'b0 : (m_f2 | hall_req2 | (car_open & d) | (car_go2 & !d));
      m_st = ns; m_f1 = n1; m_f2 = n2;
    end
  end

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string st_tag, f_tag;
    case (m_prev)
      0, 3: st_tag = "R3 state";
      2, 5: st_tag = "R4 state";
      1:    st_tag = "R5 state";
      default: st_tag = "R6 state";
    endcase
    if (rst) st_tag = "R1 state";
    chk(st_tag, {door_closed, moving, dir_down}, code_of(m_st));
    chk("R2 code", {door_closed, moving, dir_down}, code_of(m_st));
    f_tag = (m_clr1 || m_clr2) ? "R9 flags" : "R7 R8 flags";
    chk(f_tag, {1'b0, call2, call1}, {1'b0, m_f2, m_f1});
    chk("R10 complement", {1'b0, call2_n, call1_n}, {1'b0, ~call2, ~call1});
    chk("R11 legal", {2'b00, ({door_closed, moving} == 2'b01)}, 3'b000);
  endtask

  task automatic step(bit r1, bit r2, bit g1, bit g2, bit op, bit ar);
    hall_req1 = r1; hall_req2 = r2; car_go1 = g1; car_go2 = g2;
    car_open = op; arrive_i = ar;
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 reset state", {door_closed, moving, dir_down}, 3'b000);
    chk("R1 reset flags", {1'b0, call2, call1}, 3'b000);
    rst = 1'b0;
    // Idle: rest1 closes the door, then holds (R3, R5)
    step(0,0,0,0,0,0);
    chk("R3 rest1 idle to close1", {door_closed, moving, dir_down}, 3'b100);
    step(0,0,0,0,0,0);
    chk("R5 close1 holds", {door_closed, moving, dir_down}, 3'b100);
    // Open request while at floor 1, dir up: sets call1 (R7), reopens (R5)
    step(0,0,0,0,1,0);
    chk("R7 open sets call1", {1'b0, call2, call1}, 3'b001);
    step(0,0,0,0,0,0);
    chk("R5 reopen to rest1", {door_closed, moving, dir_down}, 3'b000);
    // Hall press at floor 1 while resting there: clear wins (R9)
    step(1,0,0,0,0,0);
    chk("R9 clear wins call1", {1'b0, call2, call1}, 3'b000);
    // Trip up: car_go2 with dir up (R8), then arrive (R4)
    step(0,0,0,1,0,0);
    chk("R8 car_go2 sets call2", {1'b0, call2, call1}, 3'b010);
    step(0,0,0,0,0,0);
    chk("R5 close1 to up", {door_closed, moving, dir_down}, 3'b110);
    step(0,0,0,0,0,0);
    chk("R4 up holds", {door_closed, moving, dir_down}, 3'b110);
    step(0,0,0,0,0,1);
    chk("R4 up arrive to rest2", {door_closed, moving, dir_down}, 3'b001);
    step(0,0,0,0,0,0);
    chk("R9 call2 cleared at rest2", {1'b0, call2, call1}, 3'b000);
    chk("R3 rest2 idle to close2", {door_closed, moving, dir_down}, 3'b101);
    // Random phase, sparse events
    for (int i = 0; i < RAND_CYCLES; i++) begin
      step(($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 20) == 0,
           ($urandom % 20) == 0, ($urandom % 20) == 0, ($urandom % 4) == 0);
      if (($urandom % 500) == 0) begin
        rst = 1'b1;
        step(0,0,0,0,0,0);
        rst = 1'b0;
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule